// File: doc/BRIEF.md
# Two-Bank Interrupt Register Controller

This block gathers 64 interrupt source lines into two banks of 32 and presents each bank to software as four 32-bit registers in a 64-byte window. Each line passes through a synchronizer. A rising edge on a line whose enable bit is set is stored in a sticky event bit. Software clears stored events by writing ones to an acknowledge register. A level register always shows the synchronized state of every line.

A fixed group of low-bank sources is level-sensitive. A parameter selects a narrower or a wider group. While such a line is high and enabled, it requests service through the level path, with no stored event needed. The single CPU interrupt output is a registered OR of the pending state of every source in both banks.

Enabling a line that is already high does not create an event. Software must therefore read the level register after unmasking an edge source and handle that case itself.

Top module: `dual_bank_irq_ctrl`

## Requirements
- R1: The high bank (sources 32 to 63) starts at byte offset 0x10 and the low bank (sources 0 to 31) starts at offset 0x20. Inside a bank, the registers are event at +0x0, enable at +0x4, acknowledge at +0x8 and level at +0xC. Source n is bit (n mod 32) of bank (n div 32). Data is little-endian: bits 7:0 of a word belong to its lowest byte address. Address bits 1:0 are ignored.
- R2: A read (`bus_sel`=1, `bus_wr`=0) places the addressed word on `bus_rdata` in the next cycle. In every other cycle `bus_rdata` is 0. The acknowledge register always reads as 0.
- R3: An event bit is set when the synchronized line rises while its enable bit is 1. It stays set until it is acknowledged, even if the enable bit is cleared afterwards.
- R4: Writing a word to the acknowledge register clears every event bit that has a 1 in the written word. Bits written as 0 leave their event bits unchanged.
- R5: The level register shows the synchronized state of every line, whatever the enable setting.
- R6: Setting an enable bit while the line is already high sets no event bit. For an edge source it also raises no interrupt.
- R7: In the low bank, sources 20 to 28 (mask 0x1FF00000) are level-sensitive. With `WIDE_LEVEL`=1 the group is 20 to 29 (mask 0x3FF00000). The high bank has no level-sensitive sources.
- R8: A source is pending when (event OR (level AND level mask)) AND enable is 1 for its bit. `irq_o` is the registered OR of all pending bits, so it follows the pending state one cycle later.
- R9: The enable register reads back the last value written to it, and a write takes effect in the next cycle. Reset clears all event bits, all enable bits and `irq_o`.
- R10: Writes to the event register, the level register or any offset outside both banks change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 64 | Asynchronous interrupt source lines |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
The assertions assume that `bus_sel`, `bus_wr`, `bus_addr` and `bus_wdata` are never unknown after reset, and that each write names one register per cycle. Under those assumptions, checking a register against the write data of the previous cycle is sound. The stimulus drives bus signals only at falling edges and never moves a source line in the same cycle as a bus access. Every line change is given time to pass through the synchronizer before the next access, so the bench's expected edge events match the design's cycle by cycle. Random traffic is limited to the mapped registers plus a few unmapped offsets.

// File: rtl/irqb_pkg.sv
package irqb_pkg;
  localparam int unsigned BANK_W        = 32;
  localparam int unsigned REGS_PER_BANK = 4;

  typedef logic [BANK_W-1:0] bank_word_t;

  typedef enum logic [1:0] {
    OFS_EVENT  = 2'd0,
    OFS_ENABLE = 2'd1,
    OFS_ACK    = 2'd2,
    OFS_LEVEL  = 2'd3
  } reg_ofs_e;

  // Which sources of a bank are level-sensitive.
  function automatic bank_word_t level_mask_for(int unsigned bank, bit wide);
    if (bank != 0) return '0;
    return wide ? 32'h3FF0_0000 : 32'h1FF0_0000;
  endfunction

  // Word index (byte address / 4) of the first register of a bank.
  function automatic logic [3:0] bank_word_base(int unsigned bank, int unsigned nbanks);
    return 4'((nbanks - bank) * REGS_PER_BANK);
  endfunction

  function automatic bank_word_t pending_of(bank_word_t evt, bank_word_t lvl,
                                            bank_word_t mask, bank_word_t en);
    return (evt | (lvl & mask)) & en;
  endfunction
endpackage

// File: rtl/irqb_sync.sv
module irqb_sync #(
  parameter int unsigned W      = 64,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] level_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) stg[i] <= '0;
      prev_q <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
      prev_q <= stg[STAGES-1];
    end
  end

  assign level_o = stg[STAGES-1];
  assign rise_o  = stg[STAGES-1] & ~prev_q;
endmodule

// File: rtl/irqb_bank.sv
module irqb_bank
  import irqb_pkg::*;
#(
  parameter int unsigned BANK_IDX   = 0,
  parameter bit          WIDE_LEVEL = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  bank_word_t rise_i,
  input  bank_word_t level_i,
  input  logic       en_we,
  input  logic       ack_we,
  input  bank_word_t wdata,
  output bank_word_t event_o,
  output bank_word_t enable_o,
  output bank_word_t pending_o
);
  localparam bank_word_t LVL_MASK = level_mask_for(BANK_IDX, WIDE_LEVEL);

  bank_word_t event_q, enable_q;
  bank_word_t set_vec, clr_vec;

  assign set_vec = rise_i & enable_q;
  assign clr_vec = ack_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      event_q  <= '0;
      enable_q <= '0;
    end else begin
      event_q <= (event_q & ~clr_vec) | set_vec;
      if (en_we) enable_q <= wdata;
    end
  end

  assign event_o   = event_q;
  assign enable_o  = enable_q;
  assign pending_o = pending_of(event_q, level_i, LVL_MASK, enable_q);

  // R4: acknowledged bits are clear next cycle unless a new edge arrived
  p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_we |=> ((event_q & $past(wdata & ~(rise_i & enable_q))) == '0));

  // R3 / R6: a new event bit needs an enabled rising edge in the cycle before
  p_event_needs_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((event_q & ~$past(event_q) & ~$past(rise_i & enable_q)) == '0));

  // R3: without an acknowledge write no event bit drops
  p_event_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_we |=> (($past(event_q) & ~event_q) == '0));

  // R9: enable reads back the written word
  p_enable_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    en_we |=> (enable_q == $past(wdata)));
endmodule

// File: rtl/irqb_regif.sv
module irqb_regif
  import irqb_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_sel,
  input  logic                          bus_wr,
  input  logic [5:0]                    bus_addr,
  input  logic [NUM_BANKS-1:0][BANK_W-1:0] event_i,
  input  logic [NUM_BANKS-1:0][BANK_W-1:0] enable_i,
  input  logic [NUM_BANKS-1:0][BANK_W-1:0] level_i,
  output logic [NUM_BANKS-1:0]          en_we,
  output logic [NUM_BANKS-1:0]          ack_we,
  output bank_word_t                    rdata_o
);
  logic [3:0]           word;
  reg_ofs_e             ofs;
  logic [NUM_BANKS-1:0] hit;
  bank_word_t           rd_next, rdata_q;

  assign word = bus_addr[5:2];
  assign ofs  = reg_ofs_e'(word[1:0]);

  for (genvar b = 0; b < int'(NUM_BANKS); b++) begin : g_dec
    localparam logic [3:0] BASE = bank_word_base(b, NUM_BANKS);
    assign hit[b]    = (word[3:2] == BASE[3:2]);
    assign en_we[b]  = bus_sel & bus_wr & hit[b] & (ofs == OFS_ENABLE);
    assign ack_we[b] = bus_sel & bus_wr & hit[b] & (ofs == OFS_ACK);
  end

  always_comb begin
    rd_next = '0;
    for (int b = 0; b < int'(NUM_BANKS); b++) begin
      if (hit[b]) begin
        case (ofs)
          OFS_EVENT:  rd_next = event_i[b];
          OFS_ENABLE: rd_next = enable_i[b];
          OFS_LEVEL:  rd_next = level_i[b];
          default:    rd_next = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                rdata_q <= '0;
    else if (bus_sel && !bus_wr) rdata_q <= rd_next;
    else                       rdata_q <= '0;
  end

  assign rdata_o = rdata_q;

  // R1: one write targets at most one register
  p_single_target_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({en_we, ack_we}));

  // R2: the acknowledge offset always reads zero
  p_ack_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && word[1:0] == 2'd2) |=> (rdata_o == '0));
endmodule

// File: rtl/dual_bank_irq_ctrl.sv
module dual_bank_irq_ctrl
  import irqb_pkg::*;
#(
  parameter int unsigned NUM_BANKS   = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          WIDE_LEVEL  = 1'b0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_BANKS*BANK_W-1:0] src_i,
  input  logic                        bus_sel,
  input  logic                        bus_wr,
  input  logic [5:0]                  bus_addr,
  input  logic [31:0]                 bus_wdata,
  output logic [31:0]                 bus_rdata,
  output logic                        irq_o
);
  localparam int unsigned LINES = NUM_BANKS * BANK_W;

  logic [LINES-1:0] level_all, rise_all;
  logic [NUM_BANKS-1:0][BANK_W-1:0] event_b, enable_b, level_b, pending_b;
  logic [NUM_BANKS-1:0] en_we, ack_we;
  logic any_pending, any_enable, irq_q;

  irqb_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(src_i),
    .level_o(level_all), .rise_o(rise_all));

  for (genvar b = 0; b < int'(NUM_BANKS); b++) begin : g_bank
    assign level_b[b] = level_all[b*BANK_W +: BANK_W];
    irqb_bank #(.BANK_IDX(b), .WIDE_LEVEL(WIDE_LEVEL)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .rise_i(rise_all[b*BANK_W +: BANK_W]),
      .level_i(level_all[b*BANK_W +: BANK_W]),
      .en_we(en_we[b]), .ack_we(ack_we[b]), .wdata(bus_wdata),
      .event_o(event_b[b]), .enable_o(enable_b[b]), .pending_o(pending_b[b]));
  end

  irqb_regif #(.NUM_BANKS(NUM_BANKS)) u_regif (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .event_i(event_b), .enable_i(enable_b),
    .level_i(level_b), .en_we(en_we), .ack_we(ack_we), .rdata_o(bus_rdata));

  assign any_pending = |pending_b;
  assign any_enable  = |enable_b;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= any_pending;
  end

  assign irq_o = irq_q;

  // R8: a request is only raised when some source was enabled
  p_irq_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(any_enable));
endmodule

// File: tb/test_dual_bank_irq_ctrl.sv
module test_dual_bank_irq_ctrl;
  localparam bit WIDE = 1'b0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src = '0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [63:0] m_evt = '0, m_en = '0, m_lines = '0;

  always #10 clk = ~clk;

  dual_bank_irq_ctrl #(.WIDE_LEVEL(WIDE)) i_dual_bank_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_sel(sel), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq));

  function automatic logic [63:0] lvl_mask64();
    logic [63:0] m = '0;
    int top = WIDE ? 29 : 28;
    for (int k = 20; k <= top; k++) m[k] = 1'b1;
    return m;
  endfunction

  function automatic logic [31:0] exp_read(logic [5:0] a);
    int bank;
    logic [63:0] v;
    if (a[5:4] == 2'b10)      bank = 0;
    else if (a[5:4] == 2'b01) bank = 1;
    else return '0;
    case (a[3:2])
      2'd0: v = m_evt;
      2'd1: v = m_en;
      2'd3: v = m_lines;
      default: v = '0;
    endcase
    return bank == 0 ? v[31:0] : v[63:32];
  endfunction

  function automatic logic exp_irq();
    return |((m_evt | (m_lines & lvl_mask64())) & m_en);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_lines(logic [63:0] v);
    @(negedge clk);
    m_evt   = m_evt | (v & ~m_lines & m_en);
    m_lines = v;
    src     = v;
    repeat (5) @(negedge clk);
  endtask

  task automatic bus_write(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk);
    sel = 0; wr = 0;
    if (a[5:4] == 2'b10 && a[3:2] == 2'd1) m_en[31:0]  = d;
    if (a[5:4] == 2'b01 && a[3:2] == 2'd1) m_en[63:32] = d;
    if (a[5:4] == 2'b10 && a[3:2] == 2'd2) m_evt[31:0]  &= ~d;
    if (a[5:4] == 2'b01 && a[3:2] == 2'd2) m_evt[63:32] &= ~d;
    @(negedge clk);
  endtask

  task automatic bus_read(logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1; wr = 0; addr = a;
    @(negedge clk);
    d = rdata;
    sel = 0;
  endtask

  task automatic rd_check(string req, logic [5:0] a);
    logic [31:0] d;
    bus_read(a, d);
    check(req, d, exp_read(a));
  endtask

  task automatic check_all();
    rd_check("R3 event low", 6'h20);
    rd_check("R9 enable low", 6'h24);
    rd_check("R2 ack low reads 0", 6'h28);
    rd_check("R5 level low", 6'h2C);
    rd_check("R3 event high", 6'h10);
    rd_check("R9 enable high", 6'h14);
    rd_check("R5 level high", 6'h1C);
    rd_check("R10 unmapped", 6'h04);
    @(negedge clk);
    check("R2 idle rdata", rdata, '0);
    check("R8 irq", {31'd0, irq}, {31'd0, exp_irq()});
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    check("R9 reset irq", {31'd0, irq}, '0);
    rst_n = 1;
    @(negedge clk);
    check_all();

    // R6: already-high line, enable then: no event, no irq
    set_lines(64'h8);
    bus_write(6'h24, 32'h8);
    check("R6 no event on enable", exp_read(6'h20), 32'h0);
    rd_check("R6 event low", 6'h20);
    check("R6 no irq", {31'd0, irq}, '0);
    // R3: new edge with enable set
    set_lines(64'h0);
    set_lines(64'h8);
    rd_check("R3 event set", 6'h20);
    check("R3 irq raised", {31'd0, irq}, 32'd1);
    bus_write(6'h24, 32'h0);
    rd_check("R3 sticky after disable", 6'h20);
    check("R8 disabled no irq", {31'd0, irq}, '0);
    // R4: zero bits keep, one bits clear
    bus_write(6'h28, 32'h7);
    rd_check("R4 zeros keep event", 6'h20);
    bus_write(6'h28, 32'h8);
    rd_check("R4 ones clear event", 6'h20);
    // R7: level source 22 requests while high
    set_lines(64'h0040_0000);
    bus_write(6'h24, 32'h0040_0000);
    check("R7 level irq", {31'd0, irq}, 32'd1);
    rd_check("R7 no event on level", 6'h20);
    set_lines(64'h0);
    check("R7 level drop irq", {31'd0, irq}, '0);
    // R7: bit 29 only level-sensitive in wide variant
    set_lines(64'h2000_0000);
    bus_write(6'h24, 32'h2000_0000);
    check("R7 bit29 per variant", {31'd0, irq}, {31'd0, exp_irq()});
    set_lines(64'h0);
    bus_write(6'h24, 32'h0);
    // R1: source 40 in high bank at 0x10
    bus_write(6'h14, 32'h100);
    set_lines(64'h100_0000_0000);
    bus_read(6'h10, d);
    check("R1 high bank event bit 8", d, 32'h100);
    check("R1 high bank irq", {31'd0, irq}, 32'd1);
    bus_write(6'h1B, 32'h100);
    rd_check("R1 low addr bits ignored", 6'h10);
    // R10: writes to event, level, unmapped ignored
    set_lines(64'h0);
    set_lines(64'h100_0000_0000);
    bus_write(6'h10, 32'h0);
    bus_write(6'h1C, 32'hFFFF_FFFF);
    bus_write(6'h00, 32'hFFFF_FFFF);
    bus_write(6'h34, 32'hFFFF_FFFF);
    rd_check("R10 event unchanged", 6'h10);
    check_all();

    for (int it = 0; it < 300; it++) begin
      int op = $urandom_range(0, 5);
      case (op)
        0, 1: set_lines({$urandom(), $urandom()} & {$urandom(), $urandom()});
        2: bus_write(($urandom_range(0, 1) != 0) ? 6'h24 : 6'h14, $urandom());
        3: bus_write(($urandom_range(0, 1) != 0) ? 6'h28 : 6'h18, $urandom());
        4: bus_write(6'($urandom_range(0, 63)), $urandom());
        default: set_lines(m_lines ^ (64'd1 << $urandom_range(0, 63)));
      endcase
      check_all();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule